// File: doc/BRIEF.md
# Serial Register Access Port for a Sensor

This block is the slave side of a four-wire serial link into a small bank of sensor registers. The host opens a frame by pulling chip select low and sending a command byte that names one of eight registers and says whether to read or write it. The block then either shifts the register contents out on the data output or collects the incoming bits and hands them to the core as a single write. It runs on the chip's own clock and oversamples the serial pins through synchronisers, so the serial clock may keep running between frames.

A read of the temperature register can latch the port into a streaming mode. Each later chip-select frame then returns a fresh temperature word with no command byte. With chip select tied low the same port runs on three wires, and its only recovery is a long run of ones on the data input. That run returns the interface to waiting for a command, drops streaming mode and tells the core to restore power-on register values. The register storage itself sits outside the block, behind a plain parallel port with a same-cycle read path.

Top module: `spi_sreg_if`

## Requirements
- R1: While reset is applied and just after it, the data output enable, the data output, the write strobe and the clear strobe are all 0.
- R2: The command byte is taken MSB first, one bit per rising serial clock. Bit 6 = 1 selects a read, bits 5:3 give the register address and bit 2 requests streaming. If bit 7, bit 1 or bit 0 is 1, the byte is discarded: no data phase follows, no write occurs and the data output stays 0.
- R3: On a read, the register MSB appears on the data output at the first falling serial clock after the eighth command bit. Each later falling edge presents the next bit.
- R4: The default width table makes addresses 2, 4 and 5 sixteen bits wide. Addresses 0, 1 and 3 are eight bits wide. Addresses 6 and 7 are unused and are treated as eight bits.
- R5: A write is committed as one single-cycle write strobe after its last data bit, with the data received MSB first. An 8-bit write is zero-extended to 16 bits.
- R6: If chip select rises before a write's last bit, there is no write strobe, and the next frame starts with a command byte.
- R7: Reads of unused addresses return zeros, whatever the core supplies. Writes to them produce no write strobe.
- R8: The data output is driven (enable 1) only while chip select is low. While chip select is high, both enable and data are 0.
- R9: After a read of address 2 with bit 2 set, each chip-select falling edge presents the temperature MSB without a command, and 16 clocks return the full word. A falling serial clock that comes before the first rising edge of the frame does not advance the data.
- R10: With chip select held low, transactions follow back to back. In streaming mode the temperature word repeats every 16 clocks, and each repetition reloads the current value from the core.
- R11: 32 consecutive rising serial clocks with data input 1 and chip select low raise the clear strobe for one cycle. They also end streaming mode and return the port to expecting a command.
- R12: After such a reset, further ones are ignored. The command begins at the first 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host (idles high) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_din | input | 1 | Serial data from the host |
| spi_dout | output | 1 | Serial data to the host |
| spi_dout_oe | output | 1 | Output enable for the data pad |
| rf_addr | output | 3 | Register address presented to the core |
| rf_rdata | input | 16 | Read data from the core for rf_addr (combinational) |
| rf_wdata | output | 16 | Write data to the core |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_clear | output | 1 | Single-cycle request to restore power-on values |

## Verification
The bench targets the edges where an off-by-one is easiest to make. It checks the first data bit after the command byte, where a design that shifts too early returns a word rotated by one. It checks a write cut short by chip select, which a sloppy design still commits. It checks a reserved bit set in the command, which a lax decoder turns into a spurious data phase. In streaming mode it checks both the MSB shown at chip-select fall and the ignored leading falling edge: a design that advances there loses the MSB, and one that never reloads repeats a stale temperature in three-wire operation. The 32-ones recovery is driven both mid-stream and with surplus ones. A design that counts wrongly, keeps streaming or misaligns the next command then reads back the wrong register.

// File: rtl/spi_sreg_pkg.sv
package spi_sreg_pkg;
    localparam int CMD_BITS  = 8;
    localparam int WORD_BITS = 16;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(WORD_BITS);

    typedef enum logic [1:0] {
        ST_CMD,
        ST_LOAD,
        ST_RD,
        ST_WR
    } sreg_state_e;

    typedef struct packed {
        sreg_state_e            state;
        logic [CNT_W-1:0]       cnt;
        logic [WORD_BITS-1:0]   sh;
        logic [2:0]             addr;
        logic                   wide;
        logic                   used;
        logic                   cont;
        logic                   armed;
        logic                   show_now;
        logic                   oe;
        logic                   dout;
        logic                   we;
        logic                   clear;
        logic [WORD_BITS-1:0]   wdata;
    } sreg_regs_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= INIT;
        else        chain_q[0] <= pin;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= INIT;
            else        chain_q[i] <= chain_q[i-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/sreg_ones_watch.sv
module sreg_ones_watch #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sample,
    input  logic bit_in,
    output logic fire,
    output logic saturated
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!active)                 run_d = '0;
        else if (sample && !bit_in)  run_d = '0;
        else if (sample && run_q != TOP) run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign fire      = active && sample && bit_in && (run_q == TOP - 1'b1);
    assign saturated = (run_q == TOP);

    p_ones_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= TOP);
    p_fire_saturates_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> saturated);
endmodule

// File: rtl/sreg_width_map.sv
module sreg_width_map #(
    parameter logic [7:0] USED_MASK = 8'b0011_1111,
    parameter logic [7:0] WIDE_MASK = 8'b0011_0100
) (
    input  logic [2:0] addr,
    output logic       used,
    output logic       wide
);
    assign used = USED_MASK[addr];
    assign wide = USED_MASK[addr] & WIDE_MASK[addr];
endmodule

// File: rtl/spi_sreg_if.sv
module spi_sreg_if
    import spi_sreg_pkg::*;
#(
    parameter logic [7:0] USED_MASK   = 8'b0011_1111,
    parameter logic [7:0] WIDE_MASK   = 8'b0011_0100,
    parameter logic [2:0] TEMP_ADDR   = 3'd2,
    parameter int         RESET_ONES  = 32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_din,
    output logic        spi_dout,
    output logic        spi_dout_oe,
    output logic [2:0]  rf_addr,
    input  logic [15:0] rf_rdata,
    output logic [15:0] rf_wdata,
    output logic        rf_we,
    output logic        rf_clear
);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_BITS - 1);

    logic sclk_lvl, sclk_rise, sclk_fall;
    logic cs_lvl, cs_rise, cs_fall;
    logic din_lvl, din_rise, din_fall;
    logic ones_fire, ones_sat;
    logic map_used, map_wide;
    logic [CMD_BITS-1:0]  cmd;
    logic [WORD_BITS-1:0] load_word;
    logic [CNT_W-1:0]     last_bit;
    sreg_regs_t r, n;

    sreg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .pin(spi_sclk),
        .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));
    sreg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .pin(spi_cs_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));
    sreg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .pin(spi_din),
        .level(din_lvl), .rise(din_rise), .fall(din_fall));

    sreg_ones_watch #(.LIMIT(RESET_ONES)) u_ones (
        .clk(clk), .rst_n(rst_n), .active(!cs_lvl), .sample(sclk_rise),
        .bit_in(din_lvl), .fire(ones_fire), .saturated(ones_sat));

    assign cmd = {r.sh[CMD_BITS-2:0], din_lvl};

    sreg_width_map #(.USED_MASK(USED_MASK), .WIDE_MASK(WIDE_MASK)) u_map (
        .addr(cmd[5:3]), .used(map_used), .wide(map_wide));

    // Word placed MSB-aligned in the shifter; unused addresses give zeros
    always_comb begin
        if (!r.used)     load_word = '0;
        else if (r.wide) load_word = rf_rdata;
        else             load_word = {rf_rdata[BYTE_BITS-1:0], {(WORD_BITS-BYTE_BITS){1'b0}}};
    end

    assign last_bit = r.wide ? WORD_LAST : BYTE_LAST;

    always_comb begin
        n       = r;
        n.we    = 1'b0;
        n.clear = 1'b0;
        n.oe    = !cs_lvl;
        if (ones_fire) begin
            n.state = ST_CMD;
            n.cnt   = '0;
            n.cont  = 1'b0;
            n.armed = 1'b0;
            n.dout  = 1'b0;
            n.clear = 1'b1;
        end else if (cs_lvl) begin
            n.state = ST_CMD;
            n.cnt   = '0;
            n.armed = 1'b0;
            n.dout  = 1'b0;
        end else if (cs_fall && r.cont) begin
            n.state    = ST_LOAD;
            n.addr     = TEMP_ADDR;
            n.used     = 1'b1;
            n.wide     = 1'b1;
            n.show_now = 1'b1;
            n.cnt      = '0;
            n.dout     = 1'b0;
        end else begin
            unique case (r.state)
                ST_CMD: begin
                    if (sclk_rise && !(ones_sat && din_lvl)) begin
                        if (r.cnt == CMD_LAST) begin
                            n.cnt = '0;
                            if (!cmd[7] && cmd[1:0] == 2'b00) begin
                                n.addr = cmd[5:3];
                                n.used = map_used;
                                n.wide = map_wide;
                                if (cmd[6]) begin
                                    n.state    = ST_LOAD;
                                    n.show_now = 1'b0;
                                    n.cont     = cmd[2] && (cmd[5:3] == TEMP_ADDR);
                                end else begin
                                    n.state = ST_WR;
                                end
                            end
                        end else begin
                            n.sh  = {r.sh[WORD_BITS-2:0], din_lvl};
                            n.cnt = r.cnt + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    n.state    = ST_RD;
                    n.cnt      = '0;
                    n.show_now = 1'b0;
                    if (r.show_now) begin
                        n.dout  = load_word[WORD_BITS-1];
                        n.sh    = {load_word[WORD_BITS-2:0], 1'b0};
                        n.armed = 1'b0;
                    end else begin
                        n.sh    = load_word;
                        n.armed = 1'b1;
                    end
                end
                ST_RD: begin
                    if (sclk_fall && r.armed) begin
                        n.dout  = r.sh[WORD_BITS-1];
                        n.sh    = {r.sh[WORD_BITS-2:0], 1'b0};
                        n.armed = 1'b0;
                    end else if (sclk_rise) begin
                        n.armed = 1'b1;
                        if (r.cnt == last_bit) begin
                            n.cnt = '0;
                            if (r.cont) begin
                                n.state = ST_LOAD;
                            end else begin
                                n.state = ST_CMD;
                                n.armed = 1'b0;
                                n.dout  = 1'b0;
                            end
                        end else begin
                            n.cnt = r.cnt + 1'b1;
                        end
                    end
                end
                ST_WR: begin
                    if (sclk_rise) begin
                        n.sh = {r.sh[WORD_BITS-2:0], din_lvl};
                        if (r.cnt == last_bit) begin
                            n.state = ST_CMD;
                            n.cnt   = '0;
                            n.we    = r.used;
                            n.wdata = r.wide ? {r.sh[WORD_BITS-2:0], din_lvl}
                                             : {{(WORD_BITS-BYTE_BITS){1'b0}},
                                                r.sh[BYTE_BITS-2:0], din_lvl};
                        end else begin
                            n.cnt = r.cnt + 1'b1;
                        end
                    end
                end
                default: n.state = ST_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r       <= '0;
            r.state <= ST_CMD;
        end else begin
            r <= n;
        end
    end

    assign spi_dout    = r.dout;
    assign spi_dout_oe = r.oe;
    assign rf_addr     = r.addr;
    assign rf_wdata    = r.wdata;
    assign rf_we       = r.we;
    assign rf_clear    = r.clear;

    // R5: a commit is always a lone one-cycle strobe
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);
    // R7: no strobe ever reaches an address outside the used set
    p_we_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> USED_MASK[rf_addr]);
    // R8: the pad carries no data while it is not enabled
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_dout_oe |-> !spi_dout);
    // R11: the recovery strobe leaves streaming off and the port awaiting a command
    p_clear_ends_cont_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_clear |-> (!r.cont && r.state == ST_CMD));
    // R3: read data only moves on a falling serial clock
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r.state == ST_RD && !sclk_fall && !sclk_rise && !cs_lvl && !ones_fire)
        |=> $stable(spi_dout));
    // R2: a discarded command leaves the port in command phase
    p_bad_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r.state == ST_CMD && sclk_rise && r.cnt == CMD_LAST && !cs_lvl && !ones_fire
         && !(ones_sat && din_lvl) && (cmd[7] || cmd[1:0] != 2'b00))
        |=> (r.state == ST_CMD && !rf_we));
endmodule

// File: tb/spi_sreg_if_test.sv
module spi_sreg_if_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        dout, dout_oe, we, clr;
    logic [2:0]  addr;
    logic [15:0] rdata, wdata;

    logic [15:0] mreg [8];
    int          tests = 0;
    int          fails = 0;
    int          we_cnt = 0;
    int          clr_cnt = 0;
    int          mon_bad = 0;
    int          cs_hi_run = 0;
    logic [2:0]  last_waddr = '0;
    logic [15:0] last_wdata = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    spi_sreg_if uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_din(din), .spi_dout(dout), .spi_dout_oe(dout_oe),
        .rf_addr(addr), .rf_rdata(rdata), .rf_wdata(wdata),
        .rf_we(we), .rf_clear(clr));

    // Behavioural core: power-on contents; 6 and 7 hold garbage the port must hide
    task automatic power_on();
        mreg[0] = 16'h0080; mreg[1] = 16'h0000; mreg[2] = 16'h0C80; mreg[3] = 16'h00C3;
        mreg[4] = 16'h2000; mreg[5] = 16'h0500; mreg[6] = 16'hBEEF; mreg[7] = 16'hDEAD;
    endtask

    assign rdata = mreg[addr];

    always @(negedge clk) begin
        if (rst_n) begin
            if (we) begin
                we_cnt++;
                last_waddr = addr;
                last_wdata = wdata;
                mreg[addr] = wdata;
            end
            if (clr) begin
                clr_cnt++;
                power_on();
            end
            cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
            if (cs_hi_run > 6 && (dout_oe || dout)) mon_bad++;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input int nb, output logic [15:0] rx);
        rx = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            sclk = 1'b0;
            din  = tx[i];
            repeat (HALF) @(negedge clk);
            rx   = {rx[14:0], dout};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        din = 1'b0;
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic rd_frame(input logic [7:0] cmd, input int nb, input string req, input int exp);
        logic [15:0] rx;
        cs_low();
        xfer({8'h00, cmd}, 8, rx);
        xfer(16'h0000, nb, rx);
        cs_high();
        chk(req, rx, exp);
    endtask

    task automatic wr_frame(input logic [7:0] cmd, input int nb, input logic [15:0] val);
        logic [15:0] rx;
        cs_low();
        xfer({8'h00, cmd}, 8, rx);
        xfer(val, nb, rx);
        cs_high();
    endtask

    initial begin
        logic [15:0] rx, rx2;
        int          w0;
        power_on();
        repeat (5) @(negedge clk);
        // R1: quiet outputs under reset
        chk("R1 oe", dout_oe, 0); chk("R1 dout", dout, 0);
        chk("R1 we", we, 0);      chk("R1 clear", clr, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 oe after reset", dout_oe, 0);

        // R3/R4: 8-bit read of address 3, 16-bit read of address 2
        rd_frame(8'h58, 8, "R3 read addr3", 16'h00C3);
        rd_frame(8'h50, 16, "R4 read addr2 wide", 16'h0C80);

        // R5: 8-bit write zero-extended, 16-bit write, both read back
        w0 = we_cnt;
        wr_frame(8'h08, 8, 16'h00A5);
        chk("R5 one strobe", we_cnt - w0, 1);
        chk("R5 addr", last_waddr, 1);
        chk("R5 byte data", last_wdata, 16'h00A5);
        rd_frame(8'h48, 8, "R5 readback addr1", 16'h00A5);
        wr_frame(8'h20, 16, 16'h1234);
        chk("R5 word data", last_wdata, 16'h1234);
        rd_frame(8'h60, 16, "R4 readback addr4", 16'h1234);

        // R6: write to address 5 cut off after 10 bits
        w0 = we_cnt;
        cs_low();
        xfer(16'h0028, 8, rx);
        xfer(16'h03FF, 10, rx);
        cs_high();
        chk("R6 no strobe", we_cnt - w0, 0);
        rd_frame(8'h68, 16, "R6 addr5 unchanged", 16'h0500);

        // R7: unused address: no strobe, zeros on read
        w0 = we_cnt;
        wr_frame(8'h30, 8, 16'h0077);
        chk("R7 no strobe", we_cnt - w0, 0);
        rd_frame(8'h70, 8, "R7 unused reads zero", 16'h0000);

        // R2: reserved bits set -> discarded, data stays 0, no write
        w0 = we_cnt;
        cs_low();
        xfer(16'h0009, 8, rx);
        xfer(16'h005A, 8, rx);
        cs_high();
        chk("R2 write discarded", we_cnt - w0, 0);
        chk("R2 dout quiet", rx, 0);
        cs_low();
        xfer(16'h0051, 8, rx);
        xfer(16'h00FF, 8, rx);
        cs_high();
        chk("R2 read discarded", rx, 0);

        // R8: pad released while deselected
        chk("R8 oe idle", dout_oe, 0);
        cs_low();
        chk("R8 oe selected", dout_oe, 1);
        cs_high();

        // R9: streaming read of temperature
        rd_frame(8'h54, 16, "R9 first stream read", 16'h0C80);
        mreg[2] = 16'h9F31;
        cs_low();
        chk("R9 MSB at select", dout, 1);
        xfer(16'h0000, 16, rx);
        cs_high();
        chk("R9 word no command", rx, 16'h9F31);
        mreg[2] = 16'h4A07;
        cs_low();
        chk("R9 MSB at select 2", dout, 0);
        xfer(16'h0000, 16, rx);
        cs_high();
        chk("R9 word refreshed", rx, 16'h4A07);

        // R11: 32 ones mid-stream
        w0 = clr_cnt;
        cs_low();
        xfer(16'hFFFF, 16, rx);
        xfer(16'hFFFF, 16, rx);
        chk("R11 clear strobe", clr_cnt - w0, 1);
        cs_high();
        cs_low();
        chk("R11 stream ended", dout, 0);
        cs_high();
        rd_frame(8'h48, 8, "R11 power-on addr1", 16'h0000);

        // R10/R12: three-wire operation, chip select held low
        cs_low();
        xfer(16'h0050, 8, rx);
        xfer(16'h0000, 16, rx);
        chk("R10 3-wire read addr2", rx, 16'h0C80);
        w0 = we_cnt;
        xfer(16'h0000, 8, rx);
        xfer(16'h007E, 8, rx);
        chk("R10 3-wire write", we_cnt - w0, 1);
        xfer(16'h0040, 8, rx);
        xfer(16'h0000, 8, rx);
        chk("R10 3-wire readback", rx, 16'h007E);
        xfer(16'h0054, 8, rx);
        xfer(16'h0000, 8, rx);
        mreg[2] = 16'hA5C3;
        xfer(16'h0000, 8, rx2);
        chk("R10 stream first", {rx[7:0], rx2[7:0]}, 16'h0C80);
        xfer(16'h0000, 16, rx);
        chk("R10 stream reload", rx, 16'hA5C3);
        w0 = clr_cnt;
        xfer(16'hFFFF, 16, rx);
        xfer(16'hFFFF, 16, rx);
        xfer(16'h00FF, 8, rx);
        chk("R12 single clear", clr_cnt - w0, 1);
        xfer(16'h0058, 8, rx);
        xfer(16'h0000, 8, rx);
        chk("R12 aligned after ones", rx, 16'h00C3);
        cs_high();

        chk("R8 idle monitor", mon_bad, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule